// File: doc/BRIEF.md
# Reconfigurable Region Safety Controller

This block sits between a host CPU and a set of partially reconfigurable compute regions. For each region it keeps a small register group that the CPU reaches over an AXI4-Lite slave port. Through this group the CPU asks for a reconfiguration, stores the start arguments for the next task, reads the region's status and clears its flags. The block watches two signals per region: one says a data frame is in flight, the other says the pipeline around the region still holds data. From these it derives a reconfiguration-safe bit, and a swap is only allowed when both are quiet.

A reconfiguration request made while the region is busy is deferred. The controller keeps watching the region and, when it becomes safe, moves it to the ready state and latches a pending flag. That flag drives the shared interrupt if the region's interrupt enable is set. Software then marks the external transfer as launched. When the transfer engine pulses done, the region is held in reset for a fixed number of cycles. Only after that reset has finished does an activate command start the new task. A done pulse that arrives at the wrong time changes no state and sets a sticky error flag.

The AXI4-Lite channels follow valid/ready rules. A write is taken only when address and data are both valid in the same cycle and no write response is still waiting. The response then stays valid until the master raises bready. Read data stays valid and unchanged until rready. No new read is taken while a read response is outstanding.

Top module: `region_guard`

## Requirements
- R1: Region r owns the word addresses r*16+0 (control), +4 (status), +8 (argument A) and +12 (argument B). Both argument registers read back what was written and drive that region's 64-bit slice of `task_arg_o`: A in bits [r*64 +: 32], B in bits [r*64+32 +: 32].
- R2: The status word reports the region's inputs and state. Bit 0 is safe, which equals neither frame busy nor pipeline busy. Bit 1 mirrors frame busy. Bit 2 mirrors pipeline busy. Bits [6:4] hold the state code: 0 run, 1 draining, 2 ready, 3 loading, 4 reset, 5 standby.
- R3: Writing 1 to control bit 0 in the run state moves the region to ready if it is safe, or to draining if it is not. In every other state that bit is ignored.
- R4: A draining region moves to ready on the first clock edge at which it is safe, and sets the pending flag (status bit 8) on that edge. A request that was safe at once sets no pending flag.
- R5: `irq_o` is the OR over all regions of pending AND interrupt enable. The interrupt enable is control bit 2, which is stored and reads back at bit 2. Writing 1 to status bit 8 clears pending.
- R6: Writing 1 to control bit 3 (transfer launched) moves a ready region to loading. In every other state that bit is ignored.
- R7: A done pulse in the loading state moves the region to reset. `region_rst_o` is then high for exactly RST_CYCLES cycles, after which the region enters standby.
- R8: Writing 1 to control bit 1 (activate) moves a standby region to run. In every other state it is ignored. `region_run_o` is high only in the run and draining states.
- R9: A done pulse outside the loading state leaves the state unchanged and sets the sticky error flag (status bit 9). Writing 1 to status bit 9 clears it.
- R10: Writes are accepted under the rules above, and bresp and rresp are always OKAY. Addresses that are not word-aligned, or that select a region index at or above NUM_REGIONS, read as zero and ignore writes.
- R11: After reset, every region is in run with zero arguments, interrupt enable clear and no flags set. `irq_o` and `region_rst_o` are low and `region_run_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data (full-word writes) |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| frame_busy_i | input | NUM_REGIONS | Per-region frame in flight |
| pipe_busy_i | input | NUM_REGIONS | Per-region pipeline holds data |
| load_done_i | input | NUM_REGIONS | Per-region transfer-complete pulse |
| region_rst_o | output | NUM_REGIONS | Per-region reset to the loaded task |
| region_run_o | output | NUM_REGIONS | Per-region task enable |
| task_arg_o | output | NUM_REGIONS*64 | Argument pairs, 64 bits per region |
| irq_o | output | 1 | Ready interrupt, level |

## Verification
The assertions check on every cycle that:
- a reset period only ends in standby;
- the run state is entered only from standby;
- a pending flag only rises as a region leaves draining;
- a stray done pulse always leaves the error flag set on the next cycle;
- response channels hold their data under back-pressure.

Only the bench scenarios can show the remaining behaviours. These are the exact reset length, the safe bit under each mix of busy inputs, the interrupt masking and clearing, the commands that are ignored in the wrong state, and the argument placement on the output bus.

// File: rtl/region_guard_pkg.sv
package region_guard_pkg;
  typedef enum logic [2:0] {
    RG_RUN     = 3'd0,
    RG_DRAIN   = 3'd1,
    RG_READY   = 3'd2,
    RG_LOAD    = 3'd3,
    RG_RESET   = 3'd4,
    RG_STANDBY = 3'd5
  } rg_state_e;

  localparam logic [1:0] REG_CTL  = 2'd0;
  localparam logic [1:0] REG_STS  = 2'd1;
  localparam logic [1:0] REG_ARGA = 2'd2;
  localparam logic [1:0] REG_ARGB = 2'd3;

  localparam int CTL_REQ  = 0;
  localparam int CTL_ACT  = 1;
  localparam int CTL_IEN  = 2;
  localparam int CTL_LOAD = 3;
  localparam int STS_PEND = 8;
  localparam int STS_ERR  = 9;
endpackage

// File: rtl/region_ctrl.sv
module region_ctrl
  import region_guard_pkg::*;
#(
  parameter int RST_CYCLES = 16,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_busy,
  input  logic              pipe_busy,
  input  logic              load_done,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ctl_word,
  output logic [DATA_W-1:0] sts_word,
  output logic [DATA_W-1:0] arg_a,
  output logic [DATA_W-1:0] arg_b,
  output logic              region_rst,
  output logic              region_run,
  output logic              irq_req
);
  localparam int CNT_W = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1;

  rg_state_e  state, nxt;
  logic [CNT_W-1:0] cnt;
  logic pend_q, err_q, ien_q, safe;
  logic wr_ctl, wr_sts;

  assign safe   = !frame_busy && !pipe_busy;
  assign wr_ctl = wr_en && (wr_sel == REG_CTL);
  assign wr_sts = wr_en && (wr_sel == REG_STS);

  always_comb begin
    nxt = state;
    case (state)
      RG_RUN:     if (wr_ctl && wr_data[CTL_REQ]) nxt = safe ? RG_READY : RG_DRAIN;
      RG_DRAIN:   if (safe) nxt = RG_READY;
      RG_READY:   if (wr_ctl && wr_data[CTL_LOAD]) nxt = RG_LOAD;
      RG_LOAD:    if (load_done) nxt = RG_RESET;
      RG_RESET:   if (cnt == '0) nxt = RG_STANDBY;
      RG_STANDBY: if (wr_ctl && wr_data[CTL_ACT]) nxt = RG_RUN;
      default:    nxt = RG_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= RG_RUN;
      cnt    <= '0;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
      ien_q  <= 1'b0;
      arg_a  <= '0;
      arg_b  <= '0;
    end else begin
      state <= nxt;
      if (state != RG_RESET && nxt == RG_RESET) cnt <= CNT_W'(RST_CYCLES - 1);
      else if (state == RG_RESET && cnt != '0) cnt <= cnt - 1'b1;
      if (state == RG_DRAIN && nxt == RG_READY) pend_q <= 1'b1;
      else if (wr_sts && wr_data[STS_PEND]) pend_q <= 1'b0;
      if (load_done && state != RG_LOAD) err_q <= 1'b1;
      else if (wr_sts && wr_data[STS_ERR]) err_q <= 1'b0;
      if (wr_ctl) ien_q <= wr_data[CTL_IEN];
      if (wr_en && wr_sel == REG_ARGA) arg_a <= wr_data;
      if (wr_en && wr_sel == REG_ARGB) arg_b <= wr_data;
    end
  end

  assign ctl_word   = {{(DATA_W-3){1'b0}}, ien_q, 2'b00};
  assign sts_word   = {{(DATA_W-10){1'b0}}, err_q, pend_q, 1'b0, state, 1'b0,
                       pipe_busy, frame_busy, safe};
  assign region_rst = (state == RG_RESET);
  assign region_run = (state == RG_RUN) || (state == RG_DRAIN);
  assign irq_req    = pend_q && ien_q;

  assert_reset_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    state == RG_RESET |=> (state == RG_RESET || state == RG_STANDBY));
  assert_run_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RG_RUN && $past(state) != RG_RUN) |-> $past(state) == RG_STANDBY);
  assert_pend_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(state) == RG_DRAIN);
  assert_stray_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done && state != RG_LOAD) |=> err_q);
endmodule

// File: rtl/guard_axil_port.sv
module guard_axil_port #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              wr_fire,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_word
);
  logic rd_fire;

  assign s_awready = s_awvalid && s_wvalid && !s_bvalid;
  assign s_wready  = s_awready;
  assign wr_fire   = s_awready;
  assign wr_addr   = s_awaddr;
  assign wr_data   = s_wdata;
  assign s_arready = !s_rvalid;
  assign rd_fire   = s_arvalid && s_arready;
  assign rd_addr   = s_araddr;
  assign s_bresp   = 2'b00;
  assign s_rresp   = 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_bvalid <= 1'b0;
      s_rvalid <= 1'b0;
      s_rdata  <= '0;
    end else begin
      if (wr_fire) s_bvalid <= 1'b1;
      else if (s_bready) s_bvalid <= 1'b0;
      if (rd_fire) begin
        s_rvalid <= 1'b1;
        s_rdata  <= rd_word;
      end else if (s_rready) begin
        s_rvalid <= 1'b0;
      end
    end
  end

  assert_bresp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (s_bvalid && !s_bready) |=> s_bvalid);
  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));
endmodule

// File: rtl/region_guard.sv
module region_guard
  import region_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int RST_CYCLES  = 16,
  parameter int ADDR_W      = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        s_awaddr,
  input  logic                     s_awvalid,
  output logic                     s_awready,
  input  logic [31:0]              s_wdata,
  input  logic                     s_wvalid,
  output logic                     s_wready,
  output logic [1:0]               s_bresp,
  output logic                     s_bvalid,
  input  logic                     s_bready,
  input  logic [ADDR_W-1:0]        s_araddr,
  input  logic                     s_arvalid,
  output logic                     s_arready,
  output logic [31:0]              s_rdata,
  output logic [1:0]               s_rresp,
  output logic                     s_rvalid,
  input  logic                     s_rready,
  input  logic [NUM_REGIONS-1:0]   frame_busy_i,
  input  logic [NUM_REGIONS-1:0]   pipe_busy_i,
  input  logic [NUM_REGIONS-1:0]   load_done_i,
  output logic [NUM_REGIONS-1:0]   region_rst_o,
  output logic [NUM_REGIONS-1:0]   region_run_o,
  output logic [NUM_REGIONS*64-1:0] task_arg_o,
  output logic                     irq_o
);
  localparam int SEL_W = ADDR_W - 4;

  logic              wr_fire;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [31:0]       wr_data, rd_word;
  logic [31:0]       ctl_w [NUM_REGIONS];
  logic [31:0]       sts_w [NUM_REGIONS];
  logic [31:0]       arga_w [NUM_REGIONS];
  logic [31:0]       argb_w [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] irq_req;
  logic [SEL_W-1:0]  wr_region, rd_region;
  logic              wr_hit, rd_hit;

  guard_axil_port #(.ADDR_W(ADDR_W), .DATA_W(32)) u_port (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_word(rd_word)
  );

  assign wr_region = wr_addr[ADDR_W-1:4];
  assign rd_region = rd_addr[ADDR_W-1:4];
  assign wr_hit = (wr_addr[1:0] == 2'b00) && (int'(wr_region) < NUM_REGIONS);
  assign rd_hit = (rd_addr[1:0] == 2'b00) && (int'(rd_region) < NUM_REGIONS);

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    region_ctrl #(.RST_CYCLES(RST_CYCLES), .DATA_W(32)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .frame_busy(frame_busy_i[r]), .pipe_busy(pipe_busy_i[r]),
      .load_done(load_done_i[r]),
      .wr_en(wr_fire && wr_hit && (wr_region == SEL_W'(r))),
      .wr_sel(wr_addr[3:2]), .wr_data(wr_data),
      .ctl_word(ctl_w[r]), .sts_word(sts_w[r]),
      .arg_a(arga_w[r]), .arg_b(argb_w[r]),
      .region_rst(region_rst_o[r]), .region_run(region_run_o[r]),
      .irq_req(irq_req[r])
    );
    assign task_arg_o[r*64 +: 64] = {argb_w[r], arga_w[r]};
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (rd_hit && rd_region == SEL_W'(i)) begin
        case (rd_addr[3:2])
          REG_CTL:  rd_word = ctl_w[i];
          REG_STS:  rd_word = sts_w[i];
          REG_ARGA: rd_word = arga_w[i];
          default:  rd_word = argb_w[i];
        endcase
      end
    end
  end

  assign irq_o = |irq_req;
endmodule

// File: tb/region_guard_test.sv
`timescale 1ns/100ps
module region_guard_test;
  localparam int NR = 2;
  localparam int RC = 5;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] s_awaddr = '0, s_araddr = '0;
  logic s_awvalid = 0, s_wvalid = 0, s_bready = 1, s_arvalid = 0, s_rready = 1;
  logic [31:0] s_wdata = '0;
  logic s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0] s_bresp, s_rresp;
  logic [31:0] s_rdata;
  logic [NR-1:0] frame_busy = '0, pipe_busy = '0, load_done = '0;
  logic [NR-1:0] region_rst, region_run;
  logic [NR*64-1:0] task_arg;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  region_guard #(.NUM_REGIONS(NR), .RST_CYCLES(RC), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .frame_busy_i(frame_busy), .pipe_busy_i(pipe_busy), .load_done_i(load_done),
    .region_rst_o(region_rst), .region_run_o(region_run),
    .task_arg_o(task_arg), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic axw(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    s_awaddr = a; s_wdata = d; s_awvalid = 1; s_wvalid = 1;
    #1;
    while (!s_awready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    s_awvalid = 0; s_wvalid = 0;
    chk("R10 bresp", {30'd0, s_bresp}, 32'd0);
    @(posedge clk); #1;
  endtask

  task automatic axr(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    s_araddr = a; s_arvalid = 1;
    #1;
    while (!s_arready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    s_arvalid = 0;
    d = s_rdata;
    @(posedge clk); #1;
  endtask

  function automatic logic [2:0] st(input logic [31:0] w);
    return w[6:4];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [AW-1:0] b;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 irq", {31'd0, irq}, 0);
    chk("R11 rst", {30'd0, region_rst}, 0);
    chk("R11 run", {30'd0, region_run}, 32'd3);
    chk("R11 args", task_arg[31:0] | task_arg[95:64], 0);
    for (int r = 0; r < NR; r++) begin
      axr(AW'(r*16+4), rd);
      chk("R11 status", rd, 32'h1);
      axr(AW'(r*16), rd);
      chk("R11 control", rd, 0);
    end
    // R1 argument map
    for (int r = 0; r < NR; r++) begin
      axw(AW'(r*16+8),  32'hA000_0000 + 32'(r*3));
      axw(AW'(r*16+12), 32'hB000_0000 + 32'(r*3+1));
    end
    for (int r = 0; r < NR; r++) begin
      axr(AW'(r*16+8), rd);  chk("R1 argA readback", rd, 32'hA000_0000 + 32'(r*3));
      axr(AW'(r*16+12), rd); chk("R1 argB readback", rd, 32'hB000_0000 + 32'(r*3+1));
      chk("R1 argA out", task_arg[r*64 +: 32], 32'hA000_0000 + 32'(r*3));
      chk("R1 argB out", task_arg[r*64+32 +: 32], 32'hB000_0000 + 32'(r*3+1));
    end
    // R10 unmapped and misaligned
    axr(AW'(NR*16+8), rd); chk("R10 unmapped read", rd, 0);
    axw(AW'(9), 32'h1234_5678);
    axr(AW'(8), rd); chk("R10 misaligned write dropped", rd, 32'hA000_0000);
    axr(AW'(9), rd); chk("R10 misaligned read", rd, 0);
    // R9 stray done
    @(negedge clk); load_done[0] = 1; @(negedge clk); load_done[0] = 0;
    axr(AW'(4), rd);
    chk("R9 err set", {31'd0, rd[9]}, 1);
    chk("R9 state kept", {29'd0, st(rd)}, 0);
    axw(AW'(4), 32'h200);
    axr(AW'(4), rd);
    chk("R9 err cleared", {31'd0, rd[9]}, 0);
    // sweep: region x busy combination x interrupt enable
    for (int r = 0; r < NR; r++) begin
      for (int c = 0; c < 4; c++) begin
        for (int e = 0; e < 2; e++) begin
          b = AW'(r*16);
          @(negedge clk);
          frame_busy[r] = c[0]; pipe_busy[r] = c[1];
          axr(b + 4, rd);
          chk("R2 status flags", {29'd0, rd[2:0]}, {29'd0, c[1], c[0], (c == 0)});
          chk("R2 state run", {29'd0, st(rd)}, 0);
          axw(b, 32'h8 | (32'(e) << 2));
          axr(b + 4, rd);
          chk("R6 load ignored in run", {29'd0, st(rd)}, 0);
          axr(b, rd);
          chk("R5 enable readback", rd, 32'(e) << 2);
          axw(b, 32'h1 | (32'(e) << 2));
          axr(b + 4, rd);
          if (c == 0) begin
            chk("R3 safe request to ready", {29'd0, st(rd)}, 2);
            chk("R4 no pend when safe", {31'd0, rd[8]}, 0);
          end else begin
            chk("R3 busy request to draining", {29'd0, st(rd)}, 1);
            chk("R8 run while draining", {31'd0, region_run[r]}, 1);
            chk("R5 no irq while draining", {31'd0, irq}, 0);
            @(negedge clk);
            frame_busy[r] = 0; pipe_busy[r] = 0;
            @(negedge clk);
            chk("R5 irq follows enable", {31'd0, irq}, 32'(e));
            axr(b + 4, rd);
            chk("R4 ready after drain", {29'd0, st(rd)}, 2);
            chk("R4 pend set", {31'd0, rd[8]}, 1);
            axw(b + 4, 32'h100);
            chk("R5 irq cleared", {31'd0, irq}, 0);
            axr(b + 4, rd);
            chk("R5 pend cleared", {31'd0, rd[8]}, 0);
          end
          axw(b, 32'h1 | (32'(e) << 2));
          axr(b + 4, rd);
          chk("R3 request ignored in ready", {29'd0, st(rd)}, 2);
          chk("R8 no run in ready", {31'd0, region_run[r]}, 0);
          axw(b, 32'h8 | (32'(e) << 2));
          axw(b, 32'h2 | (32'(e) << 2));
          axr(b + 4, rd);
          chk("R8 activate ignored in loading", {29'd0, st(rd)}, 3);
          chk("R6 loading", {31'd0, region_run[r]}, 0);
          @(negedge clk); load_done[r] = 1;
          @(negedge clk); load_done[r] = 0;
          n = 0;
          while (region_rst[r] && n < 100) begin n++; @(negedge clk); end
          chk("R7 reset length", 32'(n), 32'(RC));
          axr(b + 4, rd);
          chk("R7 standby after reset", {29'd0, st(rd)}, 5);
          chk("R9 no err on good done", {31'd0, rd[9]}, 0);
          axw(b, 32'h2);
          chk("R8 run after activate", {31'd0, region_run[r]}, 1);
          axr(b + 4, rd);
          chk("R8 state run", {29'd0, st(rd)}, 0);
        end
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule